// File: doc/BRIEF.md
# Table-Driven PHY Configuration Loader

This block brings up a set of serial PHY lanes after reset. A start pulse sets it off. For each lane in turn it writes constant bytes from two parameter tables into two contiguous PHY address ranges. It then writes a single forced value and patches three more PHY registers by read-modify-write. It drives an indirect PHY access port as a master. It has one transaction in flight at a time and waits for the acknowledge of each before it moves to the next.

Verify mode can be selected at start. When it is, the loader reads back every table-backed address of every lane once all lanes are programmed. It compares each returned byte with the table. The first address that disagrees is latched together with its lane. A done flag marks the end of the whole sequence and stays up until the next start that is accepted.

Top module: `phy_cfg_loader`

## Requirements
- R1: While reset is asserted and right after it, `req_o`, `done_o` and `mism_o` are low.
- R2: A `start_i` pulse while idle or done makes the next cycle present the first transaction: a write on lane 0 to address 0x0065.
- R3: The loader writes window A first. The addresses run from 0x0065 up to 0x006E in ascending order, and address 0x0065+i carries table A byte i, which is bits [8i+7:8i] of `TBL1`.
- R4: The loader writes window B next. The addresses run from 0x8065 up to 0x80A4 in ascending order, and address 0x8065+i carries table B byte i, which is bits [8i+7:8i] of `TBL2`.
- R5: After window B, 0x1F is written to address 0x800F.
- R6: Next, address 0x0029 is read and written back with bits 3:1 set. The other bits keep the value that was read.
- R7: Next, address 0x0056 is read and written back with bit 3 cleared. The other bits keep the value that was read.
- R8: Last for each lane, address 0x0018 is read and written back with bits 2:0 cleared. Lane 0 receives its whole sequence before lane 1 begins, so `lane_o` is 0 and then 1.
- R9: A request stays high until it is acknowledged. Direction, lane, address and write data stay constant while it waits.
- R10: `done_o` rises after the final acknowledge and holds until the next accepted start. During a run, `start_i` and `verify_i` are ignored, and `req_o` is never high while `done_o` is high.
- R11: If `verify_i` was high at the accepted start, then after all lanes the loader reads window A and then window B of lane 0, and then of lane 1, in ascending address order. It issues no write in this phase.
- R12: In verify mode, the first read that differs from its table byte sets `mism_o` and latches its lane and address. Later mismatches do not change them. An accepted start clears the flag, and a run whose reads all match leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| verify_i | input | 1 | Read-back mode select, sampled at an accepted start |
| req_o | output | 1 | PHY access request |
| we_o | output | 1 | 1 = write, 0 = read |
| lane_o | output | LW (1) | Lane being accessed |
| addr_o | output | AW (16) | PHY register address |
| wdata_o | output | DW (8) | Write data, zero on reads |
| ack_i | input | 1 | Transaction complete; read data valid in the same cycle |
| rdata_i | input | DW (8) | Read data |
| done_o | output | 1 | Sequence finished |
| mism_o | output | 1 | Read-back mismatch seen |
| mism_lane_o | output | LW (1) | Lane of first mismatch |
| mism_addr_o | output | AW (16) | Address of first mismatch |

## Verification
A model PHY answers requests, and every transaction is logged and compared with a sequence the bench derives from R3 to R11. The loader runs once with zero-wait acknowledges, which confirms ordering and data. It runs again with a rotating wait of zero to three cycles, which shows that it holds each request rather than running ahead. The second run also pulses start and verify part-way through, to show that neither disturbs the sequence or its length. A verify run against a clean model shows that matching reads raise no flag. A run in which the model drops two lane-1 writes shows that only the earlier failing address is latched. A plain run afterwards shows that the flag clears.

// File: rtl/phy_cfg_loader.sv
module phy_cfg_loader #(
  parameter int LANES  = 2,
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int W1_LEN = 10,
  parameter int W2_LEN = 64,
  parameter logic [AW-1:0] W1_BASE = 16'h0065,
  parameter logic [AW-1:0] W2_BASE = 16'h8065,
  parameter logic [W1_LEN*DW-1:0] TBL1 = {W1_LEN{8'h00}},
  parameter logic [W2_LEN*DW-1:0] TBL2 = {W2_LEN{8'h00}},
  parameter logic [AW-1:0] FORCE_ADDR = 16'h800F,
  parameter logic [DW-1:0] FORCE_VAL  = 8'h1F,
  parameter logic [AW-1:0] SET_ADDR   = 16'h0029,
  parameter logic [DW-1:0] SET_MASK   = 8'h0E,
  parameter logic [AW-1:0] CLRA_ADDR  = 16'h0056,
  parameter logic [DW-1:0] CLRA_MASK  = 8'h08,
  parameter logic [AW-1:0] CLRB_ADDR  = 16'h0018,
  parameter logic [DW-1:0] CLRB_MASK  = 8'h07,
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int MAXW  = (W2_LEN > W1_LEN) ? W2_LEN : W1_LEN,
  localparam int IW    = (MAXW > 7) ? $clog2(MAXW) : 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          verify_i,
  output logic          req_o,
  output logic          we_o,
  output logic [LW-1:0] lane_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          done_o,
  output logic          mism_o,
  output logic [LW-1:0] mism_lane_o,
  output logic [AW-1:0] mism_addr_o
);

  typedef enum logic [2:0] {S_IDLE, S_WIN1, S_WIN2, S_FIX, S_VER1, S_VER2} phase_t;

  phase_t        phase;
  logic [IW-1:0] idx;
  logic [LW-1:0] lane;
  logic          verify_q;
  logic [DW-1:0] rmw;
  logic [DW-1:0] exp_byte;
  logic          last_idx;

  wire adv       = req_o & ack_i;
  wire lane_last = (lane == LW'(LANES - 1));
  wire in_ver    = (phase == S_VER1) || (phase == S_VER2);

  always_comb begin
    we_o     = 1'b0;
    addr_o   = '0;
    exp_byte = '0;
    last_idx = 1'b0;
    unique case (phase)
      S_WIN1, S_VER1: begin
        we_o     = (phase == S_WIN1);
        addr_o   = W1_BASE + AW'(idx);
        exp_byte = DW'(TBL1 >> (DW * idx));
        last_idx = (idx == IW'(W1_LEN - 1));
      end
      S_WIN2, S_VER2: begin
        we_o     = (phase == S_WIN2);
        addr_o   = W2_BASE + AW'(idx);
        exp_byte = DW'(TBL2 >> (DW * idx));
        last_idx = (idx == IW'(W2_LEN - 1));
      end
      S_FIX: begin
        we_o     = ~idx[0];
        last_idx = (idx == IW'(6));
        case (idx[2:0])
          3'd0:       begin addr_o = FORCE_ADDR; exp_byte = FORCE_VAL;        end
          3'd1, 3'd2: begin addr_o = SET_ADDR;   exp_byte = rmw | SET_MASK;   end
          3'd3, 3'd4: begin addr_o = CLRA_ADDR;  exp_byte = rmw & ~CLRA_MASK; end
          default:    begin addr_o = CLRB_ADDR;  exp_byte = rmw & ~CLRB_MASK; end
        endcase
      end
      default: ;
    endcase
  end

  assign req_o   = (phase != S_IDLE);
  assign lane_o  = lane;
  assign wdata_o = we_o ? exp_byte : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= S_IDLE;
      idx         <= '0;
      lane        <= '0;
      verify_q    <= 1'b0;
      rmw         <= '0;
      done_o      <= 1'b0;
      mism_o      <= 1'b0;
      mism_lane_o <= '0;
      mism_addr_o <= '0;
    end else if (phase == S_IDLE) begin
      if (start_i) begin
        phase       <= S_WIN1;
        idx         <= '0;
        lane        <= '0;
        verify_q    <= verify_i;
        done_o      <= 1'b0;
        mism_o      <= 1'b0;
        mism_lane_o <= '0;
        mism_addr_o <= '0;
      end
    end else if (adv) begin
      if (phase == S_FIX && idx[0])
        rmw <= rdata_i;
      if (in_ver && rdata_i != exp_byte && !mism_o) begin
        mism_o      <= 1'b1;
        mism_lane_o <= lane;
        mism_addr_o <= addr_o;
      end
      if (!last_idx) begin
        idx <= idx + 1'b1;
      end else begin
        idx <= '0;
        case (phase)
          S_WIN1: phase <= S_WIN2;
          S_WIN2: phase <= S_FIX;
          S_VER1: phase <= S_VER2;
          S_FIX: begin
            if (!lane_last) begin
              lane  <= lane + 1'b1;
              phase <= S_WIN1;
            end else begin
              lane <= '0;
              if (verify_q) phase <= S_VER1;
              else begin phase <= S_IDLE; done_o <= 1'b1; end
            end
          end
          default: begin
            if (!lane_last) begin
              lane  <= lane + 1'b1;
              phase <= S_VER1;
            end else begin
              lane   <= '0;
              phase  <= S_IDLE;
              done_o <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o) && $stable(lane_o));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_o);

  // R10
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(req_o && ack_i));

  // R6
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && ack_i && !we_o && addr_o == SET_ADDR |=> we_o && addr_o == SET_ADDR && (wdata_o & SET_MASK) == SET_MASK);

  // R7
  clra_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && ack_i && !we_o && addr_o == CLRA_ADDR |=> we_o && addr_o == CLRA_ADDR && (wdata_o & CLRA_MASK) == '0);

  // R8
  clrb_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && ack_i && !we_o && addr_o == CLRB_ADDR |=> we_o && addr_o == CLRB_ADDR && (wdata_o & CLRB_MASK) == '0);

  // R12
  mism_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mism_o && req_o |=> mism_o && $stable(mism_addr_o) && $stable(mism_lane_o));

endmodule

// File: tb/phy_cfg_loader_bench.sv
module phy_cfg_loader_bench;
  localparam logic [79:0]  T1 = 80'hA1B2C3D4E5F60718293A;
  localparam logic [511:0] T2 = 512'h3C5A7E9100FF12ABC4D5E6F708192A3B4C5D6E7F8091A2B3C0D1E2F3A5A55AA50F1E2D3C4B5A69788796A5B4C3D2E1F013579BDF02468ACEFDB97531ECA86420;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start_i = 1'b0, verify_i = 1'b0, ack_i = 1'b0;
  logic [7:0] rdata_i = '0;
  logic req_o, we_o, done_o, mism_o;
  logic [0:0] lane_o, mism_lane_o;
  logic [15:0] addr_o, mism_addr_o;
  logic [7:0] wdata_o;

  phy_cfg_loader #(.TBL1(T1), .TBL2(T2)) u_phy_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .verify_i(verify_i),
    .req_o(req_o), .we_o(we_o), .lane_o(lane_o), .addr_o(addr_o), .wdata_o(wdata_o),
    .ack_i(ack_i), .rdata_i(rdata_i), .done_o(done_o), .mism_o(mism_o),
    .mism_lane_o(mism_lane_o), .mism_addr_o(mism_addr_o));

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [0:1023];
  int lg_lane [0:511];
  bit lg_we [0:511];
  logic [15:0] lg_addr [0:511];
  logic [7:0] lg_data [0:511];
  int lg_n = 0;
  int ex_lane [0:511];
  bit ex_we [0:511];
  logic [15:0] ex_addr [0:511];
  logic [7:0] ex_data [0:511];
  string ex_tag [0:511];
  int ex_n = 0;
  int wcnt = 0, txn = 0;
  bit lat_mode = 0, drop_en = 0;

  function automatic int midx(int l, logic [15:0] a);
    return l * 512 + int'(a[15]) * 256 + int'(a[7:0]);
  endfunction

  function automatic logic [7:0] ival(int l, logic [15:0] a);
    return a[7:0] ^ {a[15], 7'h2A} ^ ((l == 1) ? 8'h33 : 8'h00);
  endfunction

  always @(negedge clk) begin
    if (ack_i) ack_i = 1'b0;
    else if (req_o) begin
      if (wcnt >= (lat_mode ? (txn % 4) : 0)) begin
        lg_lane[lg_n] = int'(lane_o);
        lg_we[lg_n] = we_o;
        lg_addr[lg_n] = addr_o;
        if (we_o) begin
          if (!(drop_en && lane_o == 1'b1 && (addr_o == 16'h8070 || addr_o == 16'h8080)))
            mem[midx(int'(lane_o), addr_o)] = wdata_o;
          lg_data[lg_n] = wdata_o;
        end else begin
          rdata_i = mem[midx(int'(lane_o), addr_o)];
          lg_data[lg_n] = rdata_i;
        end
        if (lg_n < 511) lg_n++;
        ack_i = 1'b1;
        wcnt = 0;
        txn++;
      end else wcnt++;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int l = 0; l < 2; l++)
      for (int a = 0; a < 512; a++)
        mem[l * 512 + a] = ival(l, (a >= 256) ? 16'(32768 + a - 256) : 16'(a));
  endtask

  task automatic push(string tag, int l, bit w, logic [15:0] a, logic [7:0] d);
    ex_tag[ex_n] = tag; ex_lane[ex_n] = l; ex_we[ex_n] = w; ex_addr[ex_n] = a; ex_data[ex_n] = d;
    ex_n++;
  endtask

  task automatic build_exp(bit ver);
    ex_n = 0;
    for (int l = 0; l < 2; l++) begin
      for (int i = 0; i < 10; i++) push("R3", l, 1, 16'h0065 + 16'(i), T1[8*i +: 8]);
      for (int i = 0; i < 64; i++) push("R4", l, 1, 16'h8065 + 16'(i), T2[8*i +: 8]);
      push("R5", l, 1, 16'h800F, 8'h1F);
      push("R6", l, 0, 16'h0029, 8'h00);
      push("R6", l, 1, 16'h0029, ival(l, 16'h0029) | 8'h0E);
      push("R7", l, 0, 16'h0056, 8'h00);
      push("R7", l, 1, 16'h0056, ival(l, 16'h0056) & 8'hF7);
      push("R8", l, 0, 16'h0018, 8'h00);
      push("R8", l, 1, 16'h0018, ival(l, 16'h0018) & 8'hF8);
    end
    if (ver)
      for (int l = 0; l < 2; l++) begin
        for (int i = 0; i < 10; i++) push("R11", l, 0, 16'h0065 + 16'(i), 8'h00);
        for (int i = 0; i < 64; i++) push("R11", l, 0, 16'h8065 + 16'(i), 8'h00);
      end
  endtask

  task automatic compare_log(bit ver);
    build_exp(ver);
    chk(lg_n == ex_n, "R10", "transaction count", lg_n, ex_n);
    for (int k = 0; k < ex_n && k < lg_n; k++) begin
      chk(lg_lane[k] == ex_lane[k], ex_tag[k], "lane", lg_lane[k], ex_lane[k]);
      chk(lg_we[k] == ex_we[k] && lg_addr[k] == ex_addr[k], ex_tag[k], "we/addr",
          {15'd0, lg_we[k], lg_addr[k]}, {15'd0, ex_we[k], ex_addr[k]});
      if (ex_we[k]) chk(lg_data[k] == ex_data[k], ex_tag[k], "wdata", lg_data[k], ex_data[k]);
    end
  endtask

  task automatic launch(bit ver);
    init_mem();
    lg_n = 0;
    txn = 0;
    @(negedge clk); start_i = 1'b1; verify_i = ver;
    @(negedge clk); start_i = 1'b0; verify_i = 1'b0;
    chk(req_o && we_o && lane_o == 1'b0 && addr_o == 16'h0065, "R2", "first request addr",
        int'(addr_o), 32'h0065);
    chk(!done_o, "R10", "done cleared by start", int'(done_o), 0);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done_o && k < 20000) begin @(negedge clk); k++; end
    chk(done_o, "R10", "done reached", int'(done_o), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!req_o && !done_o && !mism_o, "R1", "outputs in reset", {req_o, done_o, mism_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!req_o && !done_o && !mism_o, "R1", "outputs after reset", {req_o, done_o, mism_o}, 0);
  endtask

  task automatic t_plain();
    lat_mode = 0; drop_en = 0;
    launch(0);
    wait_done();
    compare_log(0);
    chk(!mism_o, "R12", "no flag without verify", int'(mism_o), 0);
    begin
      int n0 = lg_n;
      repeat (20) @(negedge clk);
      chk(done_o && !req_o && lg_n == n0, "R10", "done holds, idle", lg_n, n0);
    end
  endtask

  task automatic t_latency_and_ignored_start();
    lat_mode = 1; drop_en = 0;
    launch(0);
    repeat (5) @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); start_i = 1'b1; verify_i = 1'b1;
      @(negedge clk); start_i = 1'b0; verify_i = 1'b0;
      repeat (7) @(negedge clk);
    end
    wait_done();
    compare_log(0);
    chk(!mism_o, "R10", "mid-run verify ignored", int'(mism_o), 0);
  endtask

  task automatic t_verify_clean();
    lat_mode = 0; drop_en = 0;
    launch(1);
    wait_done();
    compare_log(1);
    chk(!mism_o, "R12", "clean verify, no flag", int'(mism_o), 0);
  endtask

  task automatic t_verify_bad();
    lat_mode = 1; drop_en = 1;
    launch(1);
    wait_done();
    compare_log(1);
    chk(mism_o, "R12", "mismatch flag", int'(mism_o), 1);
    chk(mism_lane_o == 1'b1, "R12", "mismatch lane", int'(mism_lane_o), 1);
    chk(mism_addr_o == 16'h8070, "R12", "first mismatch addr", int'(mism_addr_o), 32'h8070);
  endtask

  task automatic t_clear_flag();
    lat_mode = 0; drop_en = 0;
    launch(0);
    chk(!mism_o, "R12", "flag cleared by start", int'(mism_o), 0);
    wait_done();
    chk(!mism_o, "R12", "flag low after plain run", int'(mism_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_latency_and_ignored_start();
    t_verify_clean();
    t_verify_bad();
    t_clear_flag();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule